// File: doc/BRIEF.md
# Host Data Register Handshake Port

This block is the host-facing side of a coprocessor's mailbox. A byte-wide host bus reaches a 16-bit data register and a 16-bit status register through a single register-select address bit. The status register carries three flags that drive the handshake. The request flag tells the host that the core wants a transfer. The sequence flag tracks which byte of a 16-bit transfer comes next. The width-control flag selects between 8-bit and 16-bit data transfers.

The core side writes and reads the data register, raises the request flag, and writes the status register through a fixed protection mask. It also sees the three flags as plain wires that it can use as branch conditions. Every host access takes effect on one clock edge while its strobe is high. Read data is presented combinationally while the read strobe is high.

Top module: `hdr_port`

## Requirements
- R1: After reset, the status register and the data register are both zero. `rdata_o` is zero whenever no read strobe is active.
- R2: A host read with `cs_i`=1 and `addr_sel_i`=1 returns status bits [15:8] and changes no state.
- R3: A host write with `addr_sel_i`=1 leaves both registers unchanged.
- R4: When the width-control flag (status bit 10) is 1, every data access uses the low byte. A read returns data bits [7:0]. A write replaces bits [7:0] and keeps bits [15:8]. Either access clears the request flag (status bit 15) and leaves the sequence flag (status bit 12) unchanged.
- R5: When status bit 10 is 0, the first data access with sequence flag 0 transfers the low byte, sets the sequence flag and keeps the request flag. The next access transfers the high byte and clears both the sequence flag and the request flag.
- R6: A core load (`core_dr_load_i`) writes all 16 bits of `core_wdata_i` into the data register and sets the request flag.
- R7: `core_dr_take_i` sets the request flag and leaves the data register unchanged. `core_dr_o` always shows the data register.
- R8: A core status write keeps the status bits under mask 0x907C and takes all other bits from `core_wdata_i`.
- R9: `rqm_o`, `drs_o` and `drc_o` always equal status bits 15, 12 and 10.
- R10: In the same cycle, a core set of the request flag wins over a host clear, and a core load wins over a host write to the data register. When `rd_i` and `wr_i` are both high, the access acts as a read only.
- R11: With `cs_i`=0, the host strobes have no effect and `rdata_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host chip select |
| addr_sel_i | input | 1 | 1 selects status, 0 selects data |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte |
| core_dr_load_i | input | 1 | Core loads the data register |
| core_dr_take_i | input | 1 | Core reads the data register and raises the request flag |
| core_sr_wr_i | input | 1 | Core writes the status register under the mask |
| core_wdata_i | input | 16 | Core write word |
| core_dr_o | output | 16 | Data register contents |
| core_sr_o | output | 16 | Status register contents |
| rqm_o | output | 1 | Request flag |
| drs_o | output | 1 | Byte sequence flag |
| drc_o | output | 1 | Width-control flag (1 = 8-bit) |

## Verification
Several properties are checked on every cycle:
- the flag mirrors;
- the status-byte read path;
- that status writes change nothing;
- that the request flag rises after any core load or take;
- that the protected status bits survive core writes;
- the single-step flag effects of byte-mode and first-of-pair word-mode accesses.

Some behaviour is shown only by the bench's scenarios. This covers the actual byte values that come out across a full low-then-high sequence, and the data word assembled by two host writes. It also covers the resolution of same-cycle host and core collisions, and a read and a write strobe asserted together.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;

  typedef struct packed {
    logic sr_rd;
    logic dr_rd;
    logic dr_wr;
  } host_op_t;

endpackage

// File: rtl/hdr_host_decode.sv
module hdr_host_decode
  import hdr_pkg::*;
(
  input  logic     cs_i,
  input  logic     addr_sel_i,
  input  logic     rd_i,
  input  logic     wr_i,
  output host_op_t op_o
);

  logic dr_sel;

  assign dr_sel      = cs_i && !addr_sel_i;
  assign op_o.sr_rd  = cs_i && addr_sel_i && rd_i;
  assign op_o.dr_rd  = dr_sel && rd_i;
  // read wins when both strobes are high
  assign op_o.dr_wr  = dr_sel && wr_i && !rd_i;

endmodule

// File: rtl/hdr_byte_seq.sv
module hdr_byte_seq
  import hdr_pkg::*;
(
  input  logic  access_i,
  input  logic  drc_i,
  input  logic  drs_i,
  output lane_e lane_o,
  output logic  drs_set_o,
  output logic  drs_clr_o,
  output logic  rqm_clr_o
);

  logic word_mode;

  assign word_mode = !drc_i;
  assign lane_o    = (word_mode && drs_i) ? LANE_HI : LANE_LO;
  assign drs_set_o = access_i && word_mode && !drs_i;
  assign drs_clr_o = access_i && word_mode && drs_i;
  // byte mode completes on every access, word mode on the second
  assign rqm_clr_o = access_i && (drc_i || drs_i);

endmodule

// File: rtl/hdr_regs.sv
module hdr_regs
  import hdr_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          RQM_BIT  = 15,
  parameter int          DRS_BIT  = 12,
  parameter logic [15:0] SR_KEEP  = 16'h907C,
  localparam int         DR_W     = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  lane_e             lane_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  input  logic              core_load_i,
  input  logic              core_sr_wr_i,
  input  logic [DR_W-1:0]   core_wdata_i,
  input  logic              rqm_set_i,
  input  logic              rqm_clr_i,
  input  logic              drs_set_i,
  input  logic              drs_clr_i,
  output logic [DR_W-1:0]   dr_o,
  output logic [DR_W-1:0]   sr_o
);

  logic [DR_W-1:0] dr_q, dr_d;
  logic [DR_W-1:0] sr_q, sr_d;
  logic [DR_W-1:0] keep_mask;

  assign keep_mask = DR_W'(SR_KEEP);

  always_comb begin
    dr_d = dr_q;
    if (core_load_i) begin
      dr_d = core_wdata_i;
    end else if (host_wr_i) begin
      dr_d[int'(lane_i)*BYTE_W +: BYTE_W] = host_wdata_i;
    end
  end

  always_comb begin
    sr_d = sr_q;
    if (core_sr_wr_i) sr_d = (sr_q & keep_mask) | (core_wdata_i & ~keep_mask);
    if (drs_set_i)    sr_d[DRS_BIT] = 1'b1;
    if (drs_clr_i)    sr_d[DRS_BIT] = 1'b0;
    if (rqm_clr_i)    sr_d[RQM_BIT] = 1'b0;
    // core request takes precedence over the host clear
    if (rqm_set_i)    sr_d[RQM_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q <= '0;
      sr_q <= '0;
    end else begin
      dr_q <= dr_d;
      sr_q <= sr_d;
    end
  end

  assign dr_o = dr_q;
  assign sr_o = sr_q;

endmodule

// File: rtl/hdr_port.sv
module hdr_port
  import hdr_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter int          RQM_BIT = 15,
  parameter int          DRS_BIT = 12,
  parameter int          DRC_BIT = 10,
  parameter logic [15:0] SR_KEEP = 16'h907C,
  localparam int         DR_W    = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              addr_sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              core_dr_load_i,
  input  logic              core_dr_take_i,
  input  logic              core_sr_wr_i,
  input  logic [DR_W-1:0]   core_wdata_i,
  output logic [DR_W-1:0]   core_dr_o,
  output logic [DR_W-1:0]   core_sr_o,
  output logic              rqm_o,
  output logic              drs_o,
  output logic              drc_o
);

  host_op_t        op;
  lane_e           lane;
  logic            drs_set, drs_clr, rqm_clr;
  logic [DR_W-1:0] dr, sr;

  hdr_host_decode u_decode (
    .cs_i       (cs_i),
    .addr_sel_i (addr_sel_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .op_o       (op)
  );

  hdr_byte_seq u_seq (
    .access_i  (op.dr_rd || op.dr_wr),
    .drc_i     (sr[DRC_BIT]),
    .drs_i     (sr[DRS_BIT]),
    .lane_o    (lane),
    .drs_set_o (drs_set),
    .drs_clr_o (drs_clr),
    .rqm_clr_o (rqm_clr)
  );

  hdr_regs #(
    .BYTE_W  (BYTE_W),
    .RQM_BIT (RQM_BIT),
    .DRS_BIT (DRS_BIT),
    .SR_KEEP (SR_KEEP)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_wr_i    (op.dr_wr),
    .lane_i       (lane),
    .host_wdata_i (wdata_i),
    .core_load_i  (core_dr_load_i),
    .core_sr_wr_i (core_sr_wr_i),
    .core_wdata_i (core_wdata_i),
    .rqm_set_i    (core_dr_load_i || core_dr_take_i),
    .rqm_clr_i    (rqm_clr),
    .drs_set_i    (drs_set),
    .drs_clr_i    (drs_clr),
    .dr_o         (dr),
    .sr_o         (sr)
  );

  always_comb begin
    rdata_o = '0;
    if (op.sr_rd)      rdata_o = sr[DR_W-1 -: BYTE_W];
    else if (op.dr_rd) rdata_o = dr[int'(lane)*BYTE_W +: BYTE_W];
  end

  assign core_dr_o = dr;
  assign core_sr_o = sr;
  assign rqm_o     = sr[RQM_BIT];
  assign drs_o     = sr[DRS_BIT];
  assign drc_o     = sr[DRC_BIT];

endmodule

// File: rtl/hdr_port_chk.sv
module hdr_port_chk #(
  parameter int          BYTE_W  = 8,
  parameter int          RQM_BIT = 15,
  parameter int          DRS_BIT = 12,
  parameter int          DRC_BIT = 10,
  parameter logic [15:0] SR_KEEP = 16'h907C,
  localparam int         DR_W    = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              addr_sel_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              core_dr_load_i,
  input logic              core_dr_take_i,
  input logic              core_sr_wr_i,
  input logic [DR_W-1:0]   core_wdata_i,
  input logic [DR_W-1:0]   core_dr_o,
  input logic [DR_W-1:0]   core_sr_o,
  input logic              rqm_o,
  input logic              drs_o,
  input logic              drc_o
);

  logic            dr_acc, core_quiet;
  logic [DR_W-1:0] keep;

  assign dr_acc     = cs_i && !addr_sel_i && (rd_i || wr_i);
  assign core_quiet = !core_dr_load_i && !core_dr_take_i && !core_sr_wr_i;
  assign keep       = DR_W'(SR_KEEP);

  p_flags_mirror_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rqm_o == core_sr_o[RQM_BIT] && drs_o == core_sr_o[DRS_BIT] && drc_o == core_sr_o[DRC_BIT]);

  p_status_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && addr_sel_i && rd_i |-> rdata_o == core_sr_o[DR_W-1 -: BYTE_W]);

  p_status_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && addr_sel_i && wr_i && !rd_i && core_quiet |=> $stable(core_dr_o) && $stable(core_sr_o));

  p_byte_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_acc && drc_o && core_quiet |=> !rqm_o && $stable(drs_o));

  p_word_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_acc && !drc_o && !drs_o && core_quiet |=> drs_o && $stable(rqm_o));

  p_core_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_dr_load_i |=> rqm_o && core_dr_o == $past(core_wdata_i));

  p_core_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_dr_take_i && !core_dr_load_i |=> rqm_o && $stable(core_dr_o));

  p_sr_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_sr_wr_i && !dr_acc && !core_dr_load_i && !core_dr_take_i |=>
      ((core_sr_o & ~keep) == ($past(core_wdata_i) & ~keep)) &&
      ((core_sr_o & keep) == ($past(core_sr_o) & keep)));

  p_cs_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> rdata_o == '0);

endmodule

bind hdr_port hdr_port_chk #(
  .BYTE_W  (BYTE_W),
  .RQM_BIT (RQM_BIT),
  .DRS_BIT (DRS_BIT),
  .DRC_BIT (DRC_BIT),
  .SR_KEEP (SR_KEEP)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cs_i           (cs_i),
  .addr_sel_i     (addr_sel_i),
  .rd_i           (rd_i),
  .wr_i           (wr_i),
  .rdata_o        (rdata_o),
  .core_dr_load_i (core_dr_load_i),
  .core_dr_take_i (core_dr_take_i),
  .core_sr_wr_i   (core_sr_wr_i),
  .core_wdata_i   (core_wdata_i),
  .core_dr_o      (core_dr_o),
  .core_sr_o      (core_sr_o),
  .rqm_o          (rqm_o),
  .drs_o          (drs_o),
  .drc_o          (drc_o)
);

// File: tb/hdr_port_test.sv
module hdr_port_test;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0, addr_sel_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        core_dr_load_i = 1'b0, core_dr_take_i = 1'b0, core_sr_wr_i = 1'b0;
  logic [15:0] core_wdata_i = '0;
  logic [15:0] core_dr_o, core_sr_o;
  logic        rqm_o, drs_o, drc_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  hdr_port uut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cs_i           (cs_i),
    .addr_sel_i     (addr_sel_i),
    .rd_i           (rd_i),
    .wr_i           (wr_i),
    .wdata_i        (wdata_i),
    .rdata_o        (rdata_o),
    .core_dr_load_i (core_dr_load_i),
    .core_dr_take_i (core_dr_take_i),
    .core_sr_wr_i   (core_sr_wr_i),
    .core_wdata_i   (core_wdata_i),
    .core_dr_o      (core_dr_o),
    .core_sr_o      (core_sr_o),
    .rqm_o          (rqm_o),
    .drs_o          (drs_o),
    .drc_o          (drc_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one combined access cycle; returns the byte seen during the strobe
  task automatic cycle(input logic c, input logic s, input logic r, input logic w,
                       input logic [7:0] hd, input logic ld, input logic tk,
                       input logic sw, input logic [15:0] cd, output logic [7:0] rv);
    @(negedge clk_i);
    cs_i = c; addr_sel_i = s; rd_i = r; wr_i = w; wdata_i = hd;
    core_dr_load_i = ld; core_dr_take_i = tk; core_sr_wr_i = sw; core_wdata_i = cd;
    #(CLK_P/4);
    rv = rdata_o;
    @(negedge clk_i);
    cs_i = 0; addr_sel_i = 0; rd_i = 0; wr_i = 0; wdata_i = '0;
    core_dr_load_i = 0; core_dr_take_i = 0; core_sr_wr_i = 0; core_wdata_i = '0;
  endtask

  task automatic host_rd(input logic s, output logic [7:0] rv);
    cycle(1, s, 1, 0, 8'h00, 0, 0, 0, 16'h0, rv);
  endtask

  task automatic host_wr(input logic s, input logic [7:0] d);
    logic [7:0] rv;
    cycle(1, s, 0, 1, d, 0, 0, 0, 16'h0, rv);
  endtask

  task automatic core_load(input logic [15:0] d);
    logic [7:0] rv;
    cycle(0, 0, 0, 0, 8'h00, 1, 0, 0, d, rv);
  endtask

  task automatic core_srw(input logic [15:0] d);
    logic [7:0] rv;
    cycle(0, 0, 0, 0, 8'h00, 0, 0, 1, d, rv);
  endtask

  task automatic t_reset();
    check("R1 sr", core_sr_o, 16'h0000);
    check("R1 dr", core_dr_o, 16'h0000);
    check("R1 rdata", {8'h0, rdata_o}, 16'h0000);
    check("R9 flags", {13'h0, rqm_o, drs_o, drc_o}, 16'h0000);
  endtask

  task automatic t_status();
    logic [7:0] rv;
    core_load(16'hBEEF);
    check("R6 dr", core_dr_o, 16'hBEEF);
    check("R6 sr", core_sr_o, 16'h8000);
    host_rd(1, rv);
    check("R2 byte", {8'h0, rv}, 16'h0080);
    check("R2 sr kept", core_sr_o, 16'h8000);
    check("R2 dr kept", core_dr_o, 16'hBEEF);
    host_wr(1, 8'hFF);
    check("R3 sr", core_sr_o, 16'h8000);
    check("R3 dr", core_dr_o, 16'hBEEF);
  endtask

  task automatic t_word();
    logic [7:0] rv;
    host_rd(0, rv);
    check("R5 lo byte", {8'h0, rv}, 16'h00EF);
    check("R5 after lo", {14'h0, rqm_o, drs_o}, 16'h0003);
    host_rd(0, rv);
    check("R5 hi byte", {8'h0, rv}, 16'h00BE);
    check("R5 after hi", {14'h0, rqm_o, drs_o}, 16'h0000);
    core_load(16'h0000);
    host_wr(0, 8'h34);
    check("R5 wr lo", core_dr_o, 16'h0034);
    check("R5 wr lo flags", {14'h0, rqm_o, drs_o}, 16'h0003);
    host_wr(0, 8'h12);
    check("R5 wr hi", core_dr_o, 16'h1234);
    check("R5 wr hi flags", {14'h0, rqm_o, drs_o}, 16'h0000);
  endtask

  task automatic t_sr_mask();
    logic [7:0] rv;
    core_srw(16'hFFFF);
    check("R8 masked", core_sr_o, 16'h6F83);
    check("R9 drc", {15'h0, drc_o}, 16'h0001);
    host_rd(1, rv);
    check("R2 status", {8'h0, rv}, 16'h006F);
    core_load(16'h5555);
    core_srw(16'h0000);
    check("R8 keep rqm", core_sr_o, 16'h8000);
    core_srw(16'h0400);
    check("R8 set drc", core_sr_o, 16'h8400);
  endtask

  task automatic t_byte();
    logic [7:0] rv;
    host_rd(0, rv);
    check("R4 rd byte", {8'h0, rv}, 16'h0055);
    check("R4 rd sr", core_sr_o, 16'h0400);
    core_load(16'hA5A5);
    host_wr(0, 8'h77);
    check("R4 wr dr", core_dr_o, 16'hA577);
    check("R4 wr sr", core_sr_o, 16'h0400);
  endtask

  task automatic t_take();
    logic [7:0] rv;
    cycle(0, 0, 0, 0, 8'h00, 0, 1, 0, 16'h0, rv);
    check("R7 rqm", {15'h0, rqm_o}, 16'h0001);
    check("R7 dr", core_dr_o, 16'hA577);
  endtask

  task automatic t_conflict();
    logic [7:0] rv;
    cycle(1, 0, 1, 0, 8'h00, 0, 1, 0, 16'h0, rv);
    check("R10 rd+take byte", {8'h0, rv}, 16'h0077);
    check("R10 rqm wins", {15'h0, rqm_o}, 16'h0001);
    cycle(1, 0, 0, 1, 8'h99, 1, 0, 0, 16'h2222, rv);
    check("R10 load wins", core_dr_o, 16'h2222);
    check("R10 load rqm", {15'h0, rqm_o}, 16'h0001);
    cycle(1, 0, 1, 1, 8'h55, 0, 0, 0, 16'h0, rv);
    check("R10 rd+wr byte", {8'h0, rv}, 16'h0022);
    check("R10 rd+wr dr", core_dr_o, 16'h2222);
    check("R10 rd+wr sr", core_sr_o, 16'h0400);
  endtask

  task automatic t_cs_idle();
    logic [7:0] rv;
    cycle(0, 0, 1, 1, 8'hAA, 0, 0, 0, 16'h0, rv);
    check("R11 rdata", {8'h0, rv}, 16'h0000);
    check("R11 dr", core_dr_o, 16'h2222);
    check("R11 sr", core_sr_o, 16'h0400);
    cycle(0, 1, 0, 1, 8'hAA, 0, 0, 0, 16'h0, rv);
    check("R11 sr sel", core_sr_o, 16'h0400);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    t_status();
    t_word();
    t_sr_mask();
    t_byte();
    t_take();
    t_conflict();
    t_cs_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule